// File: doc/BRIEF.md
# Comparator Event Interrupt Controller

This block sits behind an analog voltage comparator. It brings the comparator's asynchronous output into the clock domain and watches it for transitions. Each transition that matches a programmed event mode sets a sticky interrupt flag. An interrupt request is raised while that flag, a local enable and the global interrupt enable are all high.

Software clears the flag by writing a one to it. The interrupt controller clears it by pulsing an acknowledge. A routing enable decides whether the synchronized comparator level also drives the trigger input of a timer input-capture unit.

A second small register holds one digital-input-disable bit per analog pin. A set bit masks that pin's readback to zero.

Top module: `cmp_evt_irq_ctrl`

## Requirements
- R1: The event mode is control bits [4:3]. Code 2'b00 flags any change of the synchronized comparator output, 2'b10 flags only a 1-to-0 change, and 2'b11 flags only a 0-to-1 change.
- R2: Mode code 2'b01 is reserved and never sets the flag, whatever the comparator does.
- R3: The comparator output passes through two flops. A change of `cmp_raw_i` that is set up before clock edge k sets the flag after edge k+2 (visible on `flag_o`). Nothing changes on `flag_o` earlier.
- R4: `irq_ack_i` high at a clock edge clears the flag.
- R5: A control write (`ctrl_we_i`) with data bit [0] = 1 clears the flag. The same write with bit [0] = 0 leaves the flag unchanged.
- R6: When an event and a clear (acknowledge or write-one) fall on the same edge, the flag ends up set.
- R7: `irq_o` is high exactly while the flag, the interrupt enable (control bit [1]) and `gie_i` are all high.
- R8: While capture routing (control bit [2]) is 1, `cap_trig_o` follows the synchronized comparator output, which lags `cmp_raw_i` by two edges. While it is 0, `cap_trig_o` is 0.
- R9: `pin_rd_o[i]` equals `pin_raw_i[i]` when disable bit i is 0, and reads 0 when it is 1.
- R10: The disable register resets to zero. Writes set only bits [1:0], and `didr_rd_o[7:2]` always reads 0.
- R11: After reset, the control readback `ctrl_rd_o` is all zero: flag clear, interrupt disabled, routing off, toggle mode. Its layout is {3'b0, mode[1:0], routing, enable, flag}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_raw_i | input | 1 | Asynchronous comparator output |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data: [0] flag write-one-to-clear, [1] interrupt enable, [2] capture routing, [4:3] mode |
| didr_we_i | input | 1 | Disable register write strobe |
| didr_wdata_i | input | 8 | Disable register write data |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge strobe |
| pin_raw_i | input | 2 | Digital levels of the analog pins |
| irq_o | output | 1 | Interrupt request |
| cap_trig_o | output | 1 | Trigger to timer input capture |
| flag_o | output | 1 | Interrupt flag |
| ctrl_rd_o | output | 8 | Control register readback |
| didr_rd_o | output | 8 | Disable register readback |
| pin_rd_o | output | 2 | Masked pin readback |

## Verification
The comparator is driven in each of the four modes with three kinds of pattern: isolated single rises, isolated single falls, and dense random toggling. Single edges show which direction each mode accepts. Dense toggling shows whether back-to-back changes are each seen and whether the reserved code stays silent.

Clears are lined up with events on the same edge, which separates set-priority from clear-priority logic. A write-zero to the flag bit is tried against a write-one. Routing and pin masking are tried with their enables both on and off under random input levels.

// File: rtl/cmp_evt_irq_pkg.sv
package cmp_evt_irq_pkg;
  typedef enum logic [1:0] {
    MODE_ANY  = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_FALL = 2'b10,
    MODE_RISE = 2'b11
  } evt_mode_e;

  localparam int unsigned CTRL_FLAG_BIT = 0;
  localparam int unsigned CTRL_EN_BIT   = 1;
  localparam int unsigned CTRL_CAP_BIT  = 2;
  localparam int unsigned CTRL_MODE_LSB = 3;

  typedef struct packed {
    evt_mode_e mode;
    logic      cap_en;
    logic      irq_en;
  } ctrl_cfg_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else if (g == 0) chain_q[g] <= d_i;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_evt_irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  evt_mode_e mode_i,
  output logic      evt_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (mode_i)
      MODE_ANY:  evt_o = rise | fall;
      MODE_FALL: evt_o = fall;
      MODE_RISE: evt_o = rise;
      default:   evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmp_flag_reg.sv
module cmp_flag_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  input  logic w1c_i,
  output logic flag_o
);
  logic flag_q;

  // set beats any clear so no event is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               flag_q <= 1'b0;
    else if (set_i)            flag_q <= 1'b1;
    else if (ack_i || w1c_i)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cmp_pin_mask.sv
module cmp_pin_mask #(
  parameter int unsigned NPIN  = 2,
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [NPIN-1:0]  pin_raw_i,
  output logic [NPIN-1:0]  pin_rd_o,
  output logic [REG_W-1:0] reg_rd_o
);
  logic [NPIN-1:0] dis_q;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   dis_q[g] <= 1'b0;
      else if (we_i) dis_q[g] <= wdata_i[g];
    end
    assign pin_rd_o[g] = pin_raw_i[g] & ~dis_q[g];
  end

  always_comb begin
    reg_rd_o = '0;
    reg_rd_o[NPIN-1:0] = dis_q;
  end
endmodule

// File: rtl/cmp_evt_irq_ctrl.sv
module cmp_evt_irq_ctrl
  import cmp_evt_irq_pkg::*;
#(
  parameter int unsigned NPIN        = 2,
  parameter int unsigned REG_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_raw_i,
  input  logic             ctrl_we_i,
  input  logic [REG_W-1:0] ctrl_wdata_i,
  input  logic             didr_we_i,
  input  logic [REG_W-1:0] didr_wdata_i,
  input  logic             gie_i,
  input  logic             irq_ack_i,
  input  logic [NPIN-1:0]  pin_raw_i,
  output logic             irq_o,
  output logic             cap_trig_o,
  output logic             flag_o,
  output logic [REG_W-1:0] ctrl_rd_o,
  output logic [REG_W-1:0] didr_rd_o,
  output logic [NPIN-1:0]  pin_rd_o
);
  localparam int unsigned CFG_W = $bits(ctrl_cfg_t);

  ctrl_cfg_t cfg_q;
  logic      cmp_sync_lvl;
  logic      evt;
  logic      w1c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{mode: MODE_ANY, cap_en: 1'b0, irq_en: 1'b0};
    end else if (ctrl_we_i) begin
      cfg_q.irq_en <= ctrl_wdata_i[CTRL_EN_BIT];
      cfg_q.cap_en <= ctrl_wdata_i[CTRL_CAP_BIT];
      cfg_q.mode   <= evt_mode_e'(ctrl_wdata_i[CTRL_MODE_LSB +: 2]);
    end
  end

  assign w1c = ctrl_we_i & ctrl_wdata_i[CTRL_FLAG_BIT];

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_raw_i),
    .q_o   (cmp_sync_lvl)
  );

  cmp_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (cmp_sync_lvl),
    .mode_i(cfg_q.mode),
    .evt_o (evt)
  );

  cmp_flag_reg u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt),
    .ack_i (irq_ack_i),
    .w1c_i (w1c),
    .flag_o(flag_o)
  );

  cmp_pin_mask #(.NPIN(NPIN), .REG_W(REG_W)) u_pin (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (didr_we_i),
    .wdata_i  (didr_wdata_i),
    .pin_raw_i(pin_raw_i),
    .pin_rd_o (pin_rd_o),
    .reg_rd_o (didr_rd_o)
  );

  assign irq_o      = flag_o & cfg_q.irq_en & gie_i;
  assign cap_trig_o = cfg_q.cap_en & cmp_sync_lvl;

  always_comb begin
    ctrl_rd_o = '0;
    ctrl_rd_o[CTRL_FLAG_BIT]          = flag_o;
    ctrl_rd_o[CTRL_MODE_LSB-1 -: CFG_W-2] = {cfg_q.cap_en, cfg_q.irq_en};
    ctrl_rd_o[CTRL_MODE_LSB +: 2]     = cfg_q.mode;
  end
endmodule

// File: rtl/cmp_evt_irq_chk.sv
module cmp_evt_irq_chk #(
  parameter int unsigned NPIN  = 2,
  parameter int unsigned REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gie_i,
  input logic             irq_ack_i,
  input logic             irq_o,
  input logic             cap_trig_o,
  input logic             flag_o,
  input logic             evt_i,
  input logic [REG_W-1:0] ctrl_rd_o,
  input logic [REG_W-1:0] didr_rd_o,
  input logic [NPIN-1:0]  pin_rd_o
);
  // R2
  rsvd_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rd_o[4:3] == 2'b01) |-> !evt_i);
  // R4
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !evt_i) |=> !flag_o);
  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> flag_o);
  // R7
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && gie_i && ctrl_rd_o[1]));
  // R8
  cap_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rd_o[2] |-> !cap_trig_o);
  // R9
  pin_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_rd_o & didr_rd_o[NPIN-1:0]) == '0);
  // R10
  didr_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    didr_rd_o[REG_W-1:NPIN] == '0);
  // R3
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !evt_i) |=> !flag_o);
endmodule

bind cmp_evt_irq_ctrl cmp_evt_irq_chk #(.NPIN(NPIN), .REG_W(REG_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .gie_i     (gie_i),
  .irq_ack_i (irq_ack_i),
  .irq_o     (irq_o),
  .cap_trig_o(cap_trig_o),
  .flag_o    (flag_o),
  .evt_i     (evt),
  .ctrl_rd_o (ctrl_rd_o),
  .didr_rd_o (didr_rd_o),
  .pin_rd_o  (pin_rd_o)
);

// File: tb/cmp_evt_irq_ctrl_tb.sv
module cmp_evt_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_raw = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wd = '0;
  logic       didr_we = 1'b0;
  logic [7:0] didr_wd = '0;
  logic       gie = 1'b0;
  logic       ack = 1'b0;
  logic [1:0] pin_raw = '0;
  logic       irq, cap, flag;
  logic [7:0] ctrl_rd, didr_rd;
  logic [1:0] pin_rd;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  string tag = "R1";

  // reference state built from the requirements
  logic m_s1, m_s2, m_prev, m_flag, m_en, m_cap;
  logic [1:0] m_mode, m_dis;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_evt_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_raw_i(cmp_raw),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .didr_we_i(didr_we), .didr_wdata_i(didr_wd),
    .gie_i(gie), .irq_ack_i(ack), .pin_raw_i(pin_raw),
    .irq_o(irq), .cap_trig_o(cap), .flag_o(flag),
    .ctrl_rd_o(ctrl_rd), .didr_rd_o(didr_rd), .pin_rd_o(pin_rd)
  );

  function automatic logic exp_evt(logic [1:0] mode, logic cur, logic old);
    case (mode)
      2'b00:   return cur != old;
      2'b10:   return old & ~cur;
      2'b11:   return cur & ~old;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_s1, m_s2, m_prev, m_flag, m_en, m_cap} = '0;
      m_mode = 2'b00; m_dis = 2'b00;
    end else begin
      if (exp_evt(m_mode, m_s2, m_prev)) m_flag = 1'b1;
      else if (ack || (ctrl_we && ctrl_wd[0])) m_flag = 1'b0;
      if (ctrl_we) begin
        m_en = ctrl_wd[1]; m_cap = ctrl_wd[2]; m_mode = ctrl_wd[4:3];
      end
      if (didr_we) m_dis = didr_wd[1:0];
      m_prev = m_s2; m_s2 = m_s1; m_s1 = cmp_raw;
    end
  end

  task automatic chk(string t, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", t, got, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk({tag, " flag"}, 8'(flag), 8'(m_flag));
    chk("R7 irq", 8'(irq), 8'(m_flag & m_en & gie));
    chk("R8 cap", 8'(cap), 8'(m_cap & m_s2));
    chk("R9 pin", 8'(pin_rd), 8'(pin_raw & ~m_dis));
    chk("R10 didr", didr_rd, {6'b0, m_dis});
    chk("R11 ctrl", ctrl_rd, {3'b0, m_mode, m_cap, m_en, m_flag});
  endtask

  // one clock: inputs already driven, edge, then compare at negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
    ctrl_we = 1'b0; didr_we = 1'b0; ack = 1'b0;
  endtask

  task automatic wr_ctrl(logic [7:0] d);
    ctrl_we = 1'b1; ctrl_wd = d; tick();
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R11 R10 reset state
    chk("R11 reset ctrl", ctrl_rd, 8'h00);
    chk("R10 reset didr", didr_rd, 8'h00);
    chk("R7 reset irq", 8'(irq), 8'h0);
    rst_n = 1'b1;
    settle(2);

    // R1 toggle mode: rise and fall both flag
    tag = "R1";
    gie = 1'b1;
    wr_ctrl(8'b000_00_0_1_0);
    cmp_raw = 1'b1; settle(4);
    chk("R1 toggle rise", 8'(flag), 8'h1);
    wr_ctrl(8'h03);
    cmp_raw = 1'b0; settle(4);
    chk("R1 toggle fall", 8'(flag), 8'h1);
    // R1 falling mode ignores rise
    wr_ctrl(8'b000_10_0_1_1);
    cmp_raw = 1'b1; settle(4);
    chk("R1 fall mode on rise", 8'(flag), 8'h0);
    cmp_raw = 1'b0; settle(4);
    chk("R1 fall mode on fall", 8'(flag), 8'h1);
    // R1 rising mode ignores fall
    wr_ctrl(8'b000_11_0_1_1);
    cmp_raw = 1'b1; settle(4);
    chk("R1 rise mode on rise", 8'(flag), 8'h1);
    wr_ctrl(8'b000_11_0_1_1);
    cmp_raw = 1'b0; settle(4);
    chk("R1 rise mode on fall", 8'(flag), 8'h0);

    // R2 reserved code
    tag = "R2";
    wr_ctrl(8'b000_01_0_1_1);
    for (int i = 0; i < 10; i++) begin cmp_raw = ~cmp_raw; tick(); end
    settle(3);
    chk("R2 reserved", 8'(flag), 8'h0);

    // R3 latency + R8 routing lag
    tag = "R3";
    wr_ctrl(8'b000_11_1_1_1);
    cmp_raw = 1'b1; tick();
    chk("R8 cap after 1 edge", 8'(cap), 8'h0);
    tick();
    chk("R3 flag after 2 edges", 8'(flag), 8'h0);
    chk("R8 cap after 2 edges", 8'(cap), 8'h1);
    tick();
    chk("R3 flag after 3 edges", 8'(flag), 8'h1);
    chk("R7 irq up", 8'(irq), 8'h1);
    gie = 1'b0; #1;
    chk("R7 gie off", 8'(irq), 8'h0);
    gie = 1'b1;

    // R5 write zero keeps, write one clears
    tag = "R5";
    wr_ctrl(8'b000_11_1_1_0);
    chk("R5 write zero", 8'(flag), 8'h1);
    wr_ctrl(8'b000_11_1_1_1);
    chk("R5 write one", 8'(flag), 8'h0);

    // R4 ack clears
    tag = "R4";
    cmp_raw = 1'b0; settle(3);
    cmp_raw = 1'b1; settle(3);
    chk("R4 pre ack", 8'(flag), 8'h1);
    ack = 1'b1; tick();
    chk("R4 ack", 8'(flag), 8'h0);

    // R6 event and clear on the same edge
    tag = "R6";
    cmp_raw = 1'b0; settle(3);
    cmp_raw = 1'b1; tick(); tick();
    ack = 1'b1; ctrl_we = 1'b1; ctrl_wd = 8'b000_11_1_1_1; tick();
    chk("R6 set wins", 8'(flag), 8'h1);

    // R9 R10 disable register
    didr_we = 1'b1; didr_wd = 8'hFE; pin_raw = 2'b11; tick();
    chk("R10 upper bits", didr_rd, 8'h02);
    chk("R9 masked pins", 8'(pin_rd), 8'h01);

    // random mix
    tag = "R1";
    for (int i = 0; i < 4000; i++) begin
      cmp_raw = ($urandom % 3) == 0 ? ~cmp_raw : cmp_raw;
      gie     = ($urandom % 4) != 0;
      ack     = ($urandom % 9) == 0;
      pin_raw = 2'($urandom);
      if (($urandom % 15) == 0) begin ctrl_we = 1'b1; ctrl_wd = 8'($urandom) & 8'h1F; end
      if (($urandom % 40) == 0) begin didr_we = 1'b1; didr_wd = 8'($urandom); end
      tick();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule